// File: doc/BRIEF.md
# Per-Structure Thermal RC Temperature Estimator

This block keeps a running estimate of the temperature of several on-chip structures. Each structure is modelled as one lumped thermal capacitance that is tied through one thermal resistance to a heatsink, and the heatsink is held at a programmed constant temperature. On every clock edge the block takes that structure's power estimate for the cycle and advances its temperature by one forward-Euler step of the first-order RC equation. All structures are updated in parallel, and each has its own fixed-point accumulator. Heat flow between neighbouring structures is not modelled.

Software or a neighbouring unit programs the conductance (1/R) and the step gain (clock period over C) of each structure in fixed point, together with the heatsink temperature and two thresholds. From the estimates the block drives a stress flag and an emergency flag for each structure. It also keeps a running count of the cycles each structure has spent above the emergency threshold. A dynamic thermal manager can read the temperatures and flags to decide how strongly to throttle fetch. A build parameter chooses between one set of coefficients per structure and a single set shared by all structures.

Top module: `rcte_array`

## Requirements
- R1: While `rst_n` is low at a clock edge, every temperature register loads the current `tsink_i` value and every emergency counter loads zero.
- R2: With reset high, each clock edge updates each structure as follows, using signed integers and floor (arithmetic-shift) division: leak = floor((T − tsink)·G / 2^G_FRAC), delta = floor((P − leak)·K / 2^K_FRAC), T_next = T + delta. Here G is the conductance input, K is the step-gain input and P is the power input, all unsigned. The defaults are G_FRAC = 8 and K_FRAC = 12.
- R3: If T + delta exceeds 2^T_W − 1, the temperature saturates at 2^T_W − 1 (65535 by default) and does not wrap.
- R4: If T + delta is negative, the temperature saturates at 0 and does not wrap.
- R5: A structure whose temperature equals `tsink_i` and whose power is zero keeps its temperature unchanged.
- R6: `emerg_o[i]` is 1 exactly when temperature i is strictly greater than `thr_emerg_i`. An equal value gives 0.
- R7: `stress_o[i]` is 1 exactly when temperature i is strictly greater than `thr_stress_i`. An equal value gives 0.
- R8: Counter i increases by one at every edge at which `emerg_o[i]` was 1, and holds its value otherwise. Outside reset it never decreases.
- R9: The power applied to one structure has no effect on the temperature or flags of any other structure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_i | input | N_BLK*P_W | Power estimate per structure, structure i at bits [i*P_W +: P_W] |
| inv_r_i | input | COEF_N*G_W | Conductance 1/R, unsigned, G_FRAC fraction bits |
| k_i | input | COEF_N*K_W | Step gain (clock period / C), unsigned, K_FRAC fraction bits |
| tsink_i | input | T_W | Heatsink temperature |
| thr_emerg_i | input | T_W | Emergency threshold |
| thr_stress_i | input | T_W | Stress threshold |
| temp_o | output | N_BLK*T_W | Temperature per structure |
| emerg_o | output | N_BLK | Emergency flag per structure |
| stress_o | output | N_BLK | Stress flag per structure |
| emerg_cnt_o | output | N_BLK*CNT_W | Emergency cycle count per structure |

## Verification
Several directed patterns separate the failure modes of the datapath. A zero-power equilibrium at the heatsink temperature exposes rounding drift. Power on a single structure while the others idle exposes index crosstalk. Full power with zero conductance drives the top clamp, and a large conductance with a dropped heatsink value drives the bottom clamp. The directed patterns also set each threshold equal to the temperature and then one below it, which isolates strict from non-strict comparison. A long run of random power, coefficients, thresholds and occasional resets is then compared every cycle against an integer model of the difference equation; it catches errors in sign extension, shift direction and counter gating that the directed cases miss.

// File: rtl/rcte_pkg.sv
package rcte_pkg;
   localparam int unsigned DEF_N_BLK  = 4;
   localparam int unsigned DEF_T_W    = 16;
   localparam int unsigned DEF_P_W    = 12;
   localparam int unsigned DEF_G_W    = 12;
   localparam int unsigned DEF_G_FRAC = 8;
   localparam int unsigned DEF_K_W    = 12;
   localparam int unsigned DEF_K_FRAC = 12;
   localparam int unsigned DEF_CNT_W  = 64;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rcte_node.sv
module rcte_node #(
   parameter int unsigned T_W    = 16,
   parameter int unsigned P_W    = 12,
   parameter int unsigned G_W    = 12,
   parameter int unsigned G_FRAC = 8,
   parameter int unsigned K_W    = 12,
   parameter int unsigned K_FRAC = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [P_W-1:0] pwr_i,
   input  logic [G_W-1:0] inv_r_i,
   input  logic [K_W-1:0] k_i,
   input  logic [T_W-1:0] tsink_i,
   output logic [T_W-1:0] temp_o
);
   import rcte_pkg::*;

   localparam int unsigned PG_W  = T_W + G_W + 2;
   localparam int unsigned NET_W = max_u(PG_W, P_W + 1) + 1;
   localparam int unsigned PK_W  = NET_W + K_W + 1;
   localparam logic signed [PK_W-1:0] TMAX_S = {{(PK_W-T_W){1'b0}}, {T_W{1'b1}}};

   logic [T_W-1:0] temp_q, temp_d;

   logic signed [PG_W-1:0]  diff_s, g_s, prod_g, leak;
   logic signed [NET_W-1:0] pwr_s, leak_s, net;
   logic signed [PK_W-1:0]  net_s, k_s, prod_k, delta, temp_s, sum;
   logic                    net_pos, net_neg;

   // temperature above heatsink times conductance
   assign diff_s = $signed({{(PG_W-T_W){1'b0}}, temp_q}) - $signed({{(PG_W-T_W){1'b0}}, tsink_i});
   assign g_s    = $signed({{(PG_W-G_W){1'b0}}, inv_r_i});
   assign prod_g = diff_s * g_s;
   assign leak   = prod_g >>> G_FRAC;

   // net heat flow into the capacitance
   assign pwr_s  = $signed({{(NET_W-P_W){1'b0}}, pwr_i});
   assign leak_s = $signed({{(NET_W-PG_W){leak[PG_W-1]}}, leak});
   assign net    = pwr_s - leak_s;

   // scale by step gain and accumulate
   assign net_s  = $signed({{(PK_W-NET_W){net[NET_W-1]}}, net});
   assign k_s    = $signed({{(PK_W-K_W){1'b0}}, k_i});
   assign prod_k = net_s * k_s;
   assign delta  = prod_k >>> K_FRAC;
   assign temp_s = $signed({{(PK_W-T_W){1'b0}}, temp_q});
   assign sum    = temp_s + delta;

   assign net_pos = !net[NET_W-1] && (net != '0);
   assign net_neg = net[NET_W-1];

   always_comb begin
      if (sum[PK_W-1])        temp_d = '0;
      else if (sum > TMAX_S)  temp_d = '1;
      else                    temp_d = sum[T_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) temp_q <= tsink_i;
      else        temp_q <= temp_d;
   end

   assign temp_o = temp_q;

   // R3: net inflow never lowers the temperature (no wrap at the top)
   assert_no_wrap_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      net_pos |=> (temp_q >= $past(temp_q)));

   // R4: net outflow never raises the temperature (no wrap at the bottom)
   assert_no_wrap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      net_neg |=> (temp_q <= $past(temp_q)));

   // R5: zero power at heatsink temperature is an equilibrium
   assert_equilibrium_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwr_i == '0) && (temp_q == tsink_i)) |=> $stable(temp_q));
endmodule

// File: rtl/rcte_flag_cnt.sv
module rcte_flag_cnt #(
   parameter int unsigned T_W   = 16,
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [T_W-1:0]   temp_i,
   input  logic [T_W-1:0]   thr_emerg_i,
   input  logic [T_W-1:0]   thr_stress_i,
   output logic             emerg_o,
   output logic             stress_o,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   assign emerg_o  = temp_i > thr_emerg_i;
   assign stress_o = temp_i > thr_stress_i;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (emerg_o) cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end

   assign cnt_o = cnt_q;

   // R8: each emergency cycle adds exactly one
   assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      emerg_o |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1}));

   // R8: a cycle without emergency leaves the count alone
   assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !emerg_o |=> $stable(cnt_q));
endmodule

// File: rtl/rcte_array.sv
module rcte_array #(
   parameter int unsigned N_BLK        = rcte_pkg::DEF_N_BLK,
   parameter int unsigned T_W          = rcte_pkg::DEF_T_W,
   parameter int unsigned P_W          = rcte_pkg::DEF_P_W,
   parameter int unsigned G_W          = rcte_pkg::DEF_G_W,
   parameter int unsigned G_FRAC       = rcte_pkg::DEF_G_FRAC,
   parameter int unsigned K_W          = rcte_pkg::DEF_K_W,
   parameter int unsigned K_FRAC       = rcte_pkg::DEF_K_FRAC,
   parameter int unsigned CNT_W        = rcte_pkg::DEF_CNT_W,
   parameter bit          PER_BLK_COEF = 1'b1,
   localparam int unsigned COEF_N      = PER_BLK_COEF ? N_BLK : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_BLK*P_W-1:0]    pwr_i,
   input  logic [COEF_N*G_W-1:0]   inv_r_i,
   input  logic [COEF_N*K_W-1:0]   k_i,
   input  logic [T_W-1:0]          tsink_i,
   input  logic [T_W-1:0]          thr_emerg_i,
   input  logic [T_W-1:0]          thr_stress_i,
   output logic [N_BLK*T_W-1:0]    temp_o,
   output logic [N_BLK-1:0]        emerg_o,
   output logic [N_BLK-1:0]        stress_o,
   output logic [N_BLK*CNT_W-1:0]  emerg_cnt_o
);
   // elaboration-time parameter checks
   if (N_BLK < 1)                begin : g_bad_n  $error("N_BLK must be at least 1"); end
   if (T_W < 4 || T_W > 32)      begin : g_bad_t  $error("T_W out of range"); end
   if (G_FRAC > G_W)             begin : g_bad_g  $error("G_FRAC exceeds G_W"); end
   if (K_FRAC > K_W)             begin : g_bad_k  $error("K_FRAC exceeds K_W"); end
   if (CNT_W < 2)                begin : g_bad_c  $error("CNT_W too small"); end

   for (genvar i = 0; i < N_BLK; i++) begin : g_blk
      logic [G_W-1:0] g_sel;
      logic [K_W-1:0] k_sel;
      logic [T_W-1:0] temp_w;

      if (PER_BLK_COEF) begin : g_own
         assign g_sel = inv_r_i[i*G_W +: G_W];
         assign k_sel = k_i[i*K_W +: K_W];
      end else begin : g_shared
         assign g_sel = inv_r_i[G_W-1:0];
         assign k_sel = k_i[K_W-1:0];
      end

      rcte_node #(
         .T_W(T_W), .P_W(P_W), .G_W(G_W), .G_FRAC(G_FRAC), .K_W(K_W), .K_FRAC(K_FRAC)
      ) u_node (
         .clk     (clk),
         .rst_n   (rst_n),
         .pwr_i   (pwr_i[i*P_W +: P_W]),
         .inv_r_i (g_sel),
         .k_i     (k_sel),
         .tsink_i (tsink_i),
         .temp_o  (temp_w)
      );

      rcte_flag_cnt #(.T_W(T_W), .CNT_W(CNT_W)) u_flag (
         .clk          (clk),
         .rst_n        (rst_n),
         .temp_i       (temp_w),
         .thr_emerg_i  (thr_emerg_i),
         .thr_stress_i (thr_stress_i),
         .emerg_o      (emerg_o[i]),
         .stress_o     (stress_o[i]),
         .cnt_o        (emerg_cnt_o[i*CNT_W +: CNT_W])
      );

      assign temp_o[i*T_W +: T_W] = temp_w;

      // R1: the cycle after reset every temperature holds the heatsink value
      assert_reset_load_R1: assert property (@(posedge clk)
         (rst_n && !$past(rst_n) && !$isunknown($past(tsink_i))) |-> (temp_w == $past(tsink_i)));
   end
endmodule

// File: tb/sim_rcte_array.sv
`timescale 1ns/1ps
module sim_rcte_array;
   localparam int N = 4, TW = 16, PW = 12, GW = 12, KW = 12, CW = 64;
   localparam int GF = 8, KF = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [N*PW-1:0] pwr;
   logic [N*GW-1:0] gv;
   logic [N*KW-1:0] kv;
   logic [TW-1:0]   tsink, thr_e, thr_s;
   logic [N*TW-1:0] temp;
   logic [N-1:0]    emerg, stress;
   logic [N*CW-1:0] cnt;

   int p_a[N], g_a[N], k_a[N];
   longint mt[N], mc[N];
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   always_comb begin
      for (int b = 0; b < N; b++) begin
         pwr[b*PW +: PW] = p_a[b][PW-1:0];
         gv[b*GW +: GW]  = g_a[b][GW-1:0];
         kv[b*KW +: KW]  = k_a[b][KW-1:0];
      end
   end

   rcte_array u0 (
      .clk(clk), .rst_n(rst_n), .pwr_i(pwr), .inv_r_i(gv), .k_i(kv),
      .tsink_i(tsink), .thr_emerg_i(thr_e), .thr_stress_i(thr_s),
      .temp_o(temp), .emerg_o(emerg), .stress_o(stress), .emerg_cnt_o(cnt)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint model_next(input longint t, input longint s, input longint p,
                                         input longint g, input longint k);
      longint leak, delta, r;
      leak  = ((t - s) * g) >>> GF;
      delta = ((p - leak) * k) >>> KF;
      r = t + delta;
      if (r < 0) r = 0;
      if (r > 65535) r = 65535;
      return r;
   endfunction

   // R2 R6 R7 R8 compared every step against the model
   task automatic step(input bit rst);
      longint nt[N], nc[N];
      rst_n = !rst;
      for (int b = 0; b < N; b++) begin
         if (rst) begin
            nt[b] = tsink; nc[b] = 0;
         end else begin
            nc[b] = mc[b] + ((mt[b] > thr_e) ? 1 : 0);
            nt[b] = model_next(mt[b], tsink, p_a[b], g_a[b], k_a[b]);
         end
      end
      @(posedge clk); #1;
      for (int b = 0; b < N; b++) begin
         mt[b] = nt[b]; mc[b] = nc[b];
         chk("R2", $sformatf("temp[%0d]", b), temp[b*TW +: TW], mt[b]);
         chk("R6", $sformatf("emerg[%0d]", b), emerg[b], (mt[b] > thr_e) ? 1 : 0);
         chk("R7", $sformatf("stress[%0d]", b), stress[b], (mt[b] > thr_s) ? 1 : 0);
         chk("R8", $sformatf("cnt[%0d]", b), cnt[b*CW +: CW], mc[b]);
      end
   endtask

   task automatic set_all(input int p, input int g, input int k);
      for (int b = 0; b < N; b++) begin p_a[b] = p; g_a[b] = g; k_a[b] = k; end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      set_all(0, 64, 256);
      tsink = 16'd2000; thr_e = 16'd2100; thr_s = 16'd2050;
      for (int b = 0; b < N; b++) begin mt[b] = 0; mc[b] = 0; end
      #1;
      step(1); step(1);
      // R1: reset state
      for (int b = 0; b < N; b++) begin
         chk("R1", "temp after reset", temp[b*TW +: TW], 2000);
         chk("R1", "cnt after reset", cnt[b*CW +: CW], 0);
      end
      // R5: equilibrium at heatsink with zero power
      for (int i = 0; i < 5; i++) step(0);
      for (int b = 0; b < N; b++) chk("R5", "equilibrium temp", temp[b*TW +: TW], 2000);
      // R6 / R7: strict comparison at equality and one below
      thr_e = 16'd2000; thr_s = 16'd2000; #1;
      chk("R6", "emerg at equal threshold", emerg[0], 0);
      chk("R7", "stress at equal threshold", stress[0], 0);
      thr_e = 16'd1999; thr_s = 16'd1999; #1;
      chk("R6", "emerg one below", emerg[0], 1);
      chk("R7", "stress one below", stress[0], 1);
      step(0); step(0);
      thr_e = 16'd2100; thr_s = 16'd2050;
      // R9: power on structure 0 only
      p_a[0] = 3000;
      for (int i = 0; i < 10; i++) step(0);
      for (int b = 1; b < N; b++) chk("R9", "idle neighbour temp", temp[b*TW +: TW], 2000);
      chk("R9", "heated structure above sink", (temp[TW-1:0] > 16'd2000) ? 1 : 0, 1);
      // R3: saturation at the top
      tsink = 16'd65000; set_all(4095, 0, 4095);
      step(1);
      for (int i = 0; i < 3; i++) step(0);
      for (int b = 0; b < N; b++) chk("R3", "top clamp", temp[b*TW +: TW], 65535);
      // R4: saturation at the bottom
      tsink = 16'd1000; set_all(0, 4095, 4095);
      step(1);
      tsink = 16'd0;
      step(0);
      for (int b = 0; b < N; b++) chk("R4", "bottom clamp", temp[b*TW +: TW], 0);
      // random phase: R2 R6 R7 R8 against the model
      tsink = 16'd20000; set_all(0, 32, 512);
      step(1);
      for (int i = 0; i < 600; i++) begin
         for (int b = 0; b < N; b++) begin
            p_a[b] = int'($urandom_range(0, 4095));
            g_a[b] = int'($urandom_range(0, 300));
            k_a[b] = int'($urandom_range(0, 4095));
         end
         if (($urandom_range(0, 31)) == 0) tsink = 16'($urandom_range(0, 60000));
         thr_e = 16'($urandom_range(15000, 40000));
         thr_s = 16'($urandom_range(10000, 30000));
         step(($urandom_range(0, 99)) == 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule